// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block turns a 16-bit time constant into a square-wave bit clock. A byte-wide register port loads the time constant in two halves, starts and stops counting, and picks the count source: either every cycle of the block clock (peripheral clock) or only those cycles on which a synchronous external tick input is high. Each half period of the output lasts time constant + 2 source ticks. For a wanted rate, the time constant is floor((f + bps) / (2*bps)) - 2, and the output rate is f / (2*(TC+2)).

Each time the count expires, the block pulses a zero-count status line. The status interrupt logic uses that pulse, gated by an enable bit. A consumer-side divider then counts rising edges of the bit clock and emits a sampling tick once per 1, 16, 32 or 64 edges. This lets software compute the time constant against the already divided rate. A channel reset input stops the generator and parks the output low. The block moves no data stream, so every pin is plain control or status with no handshake.

Top module: `baud_gen`

## Requirements
- R1: After reset, `baud_out`, `zero_pulse`, `zc_irq` and `bit_tick` are low, and every register reads back 0.
- R2: Register map on `wr_addr`/`rd_addr`:
  - 0 holds time constant bits 7:0 and 1 holds bits 15:8.
  - 2 is control: bit 0 is run, bit 1 selects the peripheral clock.
  - 3 is mode, bits 7:6.
  - 4 is the interrupt enable, bit 1.
  - `rd_data` returns the stored value combinationally, and unimplemented bits read 0.
- R3: Writing control with bit 0 set while stopped starts from a low output. The first rising edge of `baud_out` comes TC+2 source ticks after the write edge, and every later half period is TC+2 ticks. With TC=0 the half period is 2 ticks.
- R4: With control bit 1 set, every clock cycle is a source tick. With it clear, only cycles with `ext_tick` high count, and with `ext_tick` held low the output never moves.
- R5: A time constant written while counting leaves the half period in progress unchanged. The new value applies from the next reload.
- R6: With control bit 0 clear, `baud_out` holds its level and no `zero_pulse` occurs.
- R7: `zero_pulse` is high for exactly the cycle in which `baud_out` shows each toggle. `zc_irq` equals `zero_pulse` when interrupt enable bit 1 is set, and is low otherwise.
- R8: A cycle with `chan_rst` high clears the run bit, drives `baud_out` low on the next cycle and keeps it low. A later start gives full TC+2 half periods again.
- R9: Mode bits 7:6 set the divider: 00 gives 1, 01 gives 16, 10 gives 32, 11 gives 64. `bit_tick` pulses with every Nth rising edge of `baud_out`, in the same cycle as that edge, counting from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (also the peripheral count source) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| ext_tick | input | 1 | External count enable, synchronous to clk |
| chan_rst | input | 1 | Channel reset: stop and park output low |
| baud_out | output | 1 | Square-wave bit clock |
| zero_pulse | output | 1 | One-cycle pulse at each count expiry |
| zc_irq | output | 1 | Zero-count interrupt request |
| bit_tick | output | 1 | Divided sampling tick for the consumer |

## Verification
A counter that reloads the wrong value shows at `baud_out` as a half period off by one or more cycles, already on the first toggle after a start. The bench therefore measures every edge spacing against TC+2. A stale run or source bit shows within one half period, either as a toggle while stopped or as a toggle while the external tick is idle. A divider that is mis-sized or left uncleared moves the first `bit_tick` off its expected cycle, tens to hundreds of cycles after start, so both the first tick and the tick spacing are compared for every mode.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int ADDR_W = 3;
  localparam int PRE_W  = 6;

  typedef enum logic [ADDR_W-1:0] {
    REG_TC_LO  = 3'd0,
    REG_TC_HI  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_MODE   = 3'd3,
    REG_IRQ_EN = 3'd4
  } reg_sel_e;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_PCLK = 1;
  localparam int IRQ_EN_ZC = 1;

  typedef enum logic [1:0] {
    DIV_1  = 2'b00,
    DIV_16 = 2'b01,
    DIV_32 = 2'b10,
    DIV_64 = 2'b11
  } div_mode_e;

  function automatic logic [PRE_W-1:0] div_last(div_mode_e m);
    case (m)
      DIV_1:   return PRE_W'(0);
      DIV_16:  return PRE_W'(15);
      DIV_32:  return PRE_W'(31);
      default: return PRE_W'(63);
    endcase
  endfunction
endpackage

// File: rtl/baud_gen_regs.sv
module baud_gen_regs
  import baud_gen_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic                chan_rst,
  output logic [2*DATA_W-1:0] tc,
  output logic                run,
  output logic                pclk_sel,
  output div_mode_e           div_mode,
  output logic                zc_ie,
  output logic                start,
  output logic [DATA_W-1:0]   rd_data
);
  logic [DATA_W-1:0] tc_lo_q, tc_hi_q;
  logic              run_q, pclk_q, zcie_q;
  div_mode_e         mode_q;

  // fresh start: run bit written to one while stopped
  always_comb begin
    start = wr_en && (reg_sel_e'(wr_addr) == REG_CTRL) && wr_data[CTRL_RUN]
            && !run_q && !chan_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_lo_q <= '0;
      tc_hi_q <= '0;
      run_q   <= 1'b0;
      pclk_q  <= 1'b0;
      zcie_q  <= 1'b0;
      mode_q  <= DIV_1;
    end else begin
      if (wr_en) begin
        case (reg_sel_e'(wr_addr))
          REG_TC_LO:  tc_lo_q <= wr_data;
          REG_TC_HI:  tc_hi_q <= wr_data;
          REG_CTRL: begin
            run_q  <= wr_data[CTRL_RUN];
            pclk_q <= wr_data[CTRL_PCLK];
          end
          REG_MODE:   mode_q <= div_mode_e'(wr_data[DATA_W-1 -: 2]);
          REG_IRQ_EN: zcie_q <= wr_data[IRQ_EN_ZC];
          default: ;
        endcase
      end
      if (chan_rst) run_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_addr))
      REG_TC_LO:  rd_data = tc_lo_q;
      REG_TC_HI:  rd_data = tc_hi_q;
      REG_CTRL: begin
        rd_data[CTRL_RUN]  = run_q;
        rd_data[CTRL_PCLK] = pclk_q;
      end
      REG_MODE:   rd_data[DATA_W-1 -: 2] = mode_q;
      REG_IRQ_EN: rd_data[IRQ_EN_ZC] = zcie_q;
      default: ;
    endcase
  end

  assign tc       = {tc_hi_q, tc_lo_q};
  assign run      = run_q;
  assign pclk_sel = pclk_q;
  assign div_mode = mode_q;
  assign zc_ie    = zcie_q;
endmodule

// File: rtl/baud_gen_count.sv
module baud_gen_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             start,
  input  logic             chan_rst,
  input  logic [CNT_W-1:0] tc,
  output logic             baud_out,
  output logic             zero_pulse,
  output logic             rise_pulse
);
  localparam int W = CNT_W + 1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] reload;

  // one extra tick spent at zero gives a half period of TC+2
  assign reload = {1'b0, tc} + W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      baud_out   <= 1'b0;
      zero_pulse <= 1'b0;
      rise_pulse <= 1'b0;
    end else begin
      zero_pulse <= 1'b0;
      rise_pulse <= 1'b0;
      if (chan_rst) begin
        cnt_q    <= '0;
        baud_out <= 1'b0;
      end else if (start) begin
        cnt_q    <= reload;
        baud_out <= 1'b0;
      end else if (run && tick) begin
        if (cnt_q == '0) begin
          cnt_q      <= reload;
          baud_out   <= ~baud_out;
          zero_pulse <= 1'b1;
          rise_pulse <= ~baud_out;
        end else begin
          cnt_q <= cnt_q - W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/baud_gen_presc.sv
module baud_gen_presc
  import baud_gen_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  logic      rise,
  input  div_mode_e mode,
  output logic      bit_tick
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] last;

  assign last     = div_last(mode);
  assign bit_tick = rise && (div_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_q <= '0;
    else if (clear)      div_q <= '0;
    else if (rise)       div_q <= (div_q == last) ? '0 : div_q + PRE_W'(1);
  end
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_tick,
  input  logic              chan_rst,
  output logic              baud_out,
  output logic              zero_pulse,
  output logic              zc_irq,
  output logic              bit_tick
);
  localparam int TC_W = 2 * DATA_W;

  logic [TC_W-1:0] tc;
  logic            run, pclk_sel, zc_ie, start, src_tick, rise;
  div_mode_e       div_mode;

  baud_gen_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .chan_rst(chan_rst),
    .tc(tc), .run(run), .pclk_sel(pclk_sel), .div_mode(div_mode),
    .zc_ie(zc_ie), .start(start), .rd_data(rd_data)
  );

  assign src_tick = pclk_sel | ext_tick;

  baud_gen_count #(.CNT_W(TC_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(src_tick), .run(run), .start(start),
    .chan_rst(chan_rst), .tc(tc), .baud_out(baud_out),
    .zero_pulse(zero_pulse), .rise_pulse(rise)
  );

  baud_gen_presc u_presc (
    .clk(clk), .rst_n(rst_n), .clear(start | chan_rst), .rise(rise),
    .mode(div_mode), .bit_tick(bit_tick)
  );

  assign zc_irq = zero_pulse & zc_ie;
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic chan_rst,
  input logic start,
  input logic run,
  input logic baud_out,
  input logic zero_pulse,
  input logic zc_irq,
  input logic bit_tick
);
  assert_toggle_needs_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_out != $past(baud_out)) && !$past(chan_rst) && !$past(start) |-> zero_pulse);

  assert_zero_means_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_pulse |-> (baud_out != $past(baud_out)));

  assert_irq_needs_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zc_irq |-> zero_pulse);

  assert_chan_rst_parks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (!baud_out && !run));

  assert_hold_when_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !$past(run) && !$past(chan_rst) && !$past(start) |-> $stable(baud_out) && !zero_pulse);

  assert_tick_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (baud_out && !$past(baud_out)));
endmodule

bind baud_gen baud_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .start(start), .run(run),
  .baud_out(baud_out), .zero_pulse(zero_pulse), .zc_irq(zc_irq),
  .bit_tick(bit_tick)
);

// File: tb/test_baud_gen.sv
`timescale 1ns/1ps
module test_baud_gen;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, ext_tick = 1'b0, chan_rst = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       baud_out, zero_pulse, zc_irq, bit_tick;

  baud_gen i_baud_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_tick(ext_tick), .chan_rst(chan_rst),
    .baud_out(baud_out), .zero_pulse(zero_pulse), .zc_irq(zc_irq), .bit_tick(bit_tick)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int exp_q[$];
  int ref_cyc = 0;
  bit mon_on = 1'b0, ext_on = 1'b0;
  logic prev_out = 1'b0;
  int zp_cnt = 0, irq_cnt = 0, bt_n = 0, bt_first = 0, bt_last = 0, bt_delta = 0;

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  // monitor: pops expected half periods as toggles appear
  always @(negedge clk) begin
    ext_tick = ext_on && (cyc % 3 == 0);
    if (zero_pulse) zp_cnt++;
    if (zc_irq) irq_cnt++;
    if (bit_tick) begin
      if (bt_n == 0) bt_first = cyc - ref_cyc;
      else           bt_delta = cyc - bt_last;
      bt_last = cyc;
      bt_n++;
    end
    if (mon_on && baud_out !== prev_out) begin
      if (exp_q.size() == 0) chk("R3 unexpected toggle at cycle offset", cyc - ref_cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        if (e >= 0) chk("R3/R5 half period", cyc - ref_cyc, e);
      end
      ref_cyc = cyc;
    end
    prev_out = baud_out;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a; #1; v = int'(rd_data);
  endtask

  task automatic go(input logic [7:0] ctrl);
    wr(3'd2, ctrl);
    ref_cyc = cyc;
    mon_on  = 1'b1;
  endtask

  task automatic kill();
    mon_on = 1'b0;
    @(negedge clk); chan_rst = 1'b1;
    @(negedge clk); chan_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic push_n(input int val, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(val);
  endtask

  task automatic set_tc(input int tc);
    wr(3'd0, 8'(tc)); wr(3'd1, 8'(tc >> 8));
  endtask

  task automatic div_run(input logic [7:0] mode, input int first, input int delta);
    wr(3'd3, mode);
    bt_n = 0;
    go(8'h03); mon_on = 1'b0;
    wait (bt_n >= 2);
    chk($sformatf("R9 first tick mode %02h", mode), bt_first, first);
    chk($sformatf("R9 tick spacing mode %02h", mode), bt_delta, delta);
    kill();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 baud_out", int'(baud_out), 0);
    chk("R1 zero_pulse", int'(zero_pulse), 0);
    chk("R1 bit_tick", int'(bit_tick), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk($sformatf("R1 reg %0d", a), v, 0);
    end

    // R2 readback
    wr(3'd0, 8'h34); wr(3'd1, 8'h12); wr(3'd3, 8'hFF); wr(3'd4, 8'hFF); wr(3'd2, 8'hFE);
    rd(3'd0, v); chk("R2 tc low", v, 'h34);
    rd(3'd1, v); chk("R2 tc high", v, 'h12);
    rd(3'd3, v); chk("R2 mode", v, 'hC0);
    rd(3'd4, v); chk("R2 irq enable", v, 'h02);
    rd(3'd2, v); chk("R2 control", v, 'h02);
    wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    repeat (20) @(negedge clk);
    chk("R6 stopped after reset", int'(baud_out), 0);

    // R3/R7 TC=3, irq disabled
    set_tc(3); zp_cnt = 0; irq_cnt = 0;
    push_n(5, 4); go(8'h03);
    wait (exp_q.size() == 0);
    chk("R7 zero pulses", zp_cnt, 4);
    chk("R7 irq masked", irq_cnt, 0);
    kill();

    // R3/R7 minimum TC=0, irq enabled
    wr(3'd4, 8'h02); set_tc(0); zp_cnt = 0; irq_cnt = 0;
    push_n(2, 6); go(8'h03);
    wait (exp_q.size() == 0);
    chk("R7 irq count", irq_cnt, 6);
    chk("R7 zero pulses tc0", zp_cnt, 6);
    kill(); wr(3'd4, 8'h00);

    // R5 mid-count time constant change
    set_tc(6);
    exp_q.push_back(8); push_n(4, 3); go(8'h03);
    repeat (3) @(negedge clk);
    wr(3'd0, 8'h02);
    wait (exp_q.size() == 0);
    kill();

    // R4 external source
    set_tc(1); zp_cnt = 0;
    go(8'h01);
    repeat (40) @(negedge clk);
    chk("R4 idle ext no pulses", zp_cnt, 0);
    chk("R4 idle ext output", int'(baud_out), 0);
    exp_q.push_back(-1); push_n(9, 3);
    ext_on = 1'b1;
    wait (exp_q.size() == 0);
    kill(); ext_on = 1'b0;

    // R6 hold while stopped
    set_tc(4);
    exp_q.push_back(6); go(8'h03);
    wait (exp_q.size() == 0);
    wr(3'd2, 8'h02); zp_cnt = 0;
    repeat (40) @(negedge clk);
    chk("R6 held high", int'(baud_out), 1);
    chk("R6 no pulses", zp_cnt, 0);
    kill();
    chk("R8 parked low", int'(baud_out), 0);

    // R8 channel reset while running
    exp_q.push_back(6); go(8'h03);
    wait (exp_q.size() == 0);
    kill(); zp_cnt = 0;
    chk("R8 low after reset", int'(baud_out), 0);
    rd(3'd2, v); chk("R8 run cleared", v, 'h02);
    repeat (30) @(negedge clk);
    chk("R8 stays low", int'(baud_out), 0);
    chk("R8 no pulses", zp_cnt, 0);
    push_n(6, 2); go(8'h03);
    wait (exp_q.size() == 0);
    kill();

    // R9 consumer divider
    set_tc(0);
    div_run(8'h40, 62, 64);
    div_run(8'hC0, 254, 256);
    div_run(8'h00, 2, 4);
    div_run(8'h80, 126, 128);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule